// File: doc/BRIEF.md
# Double to Signed Integer Truncating Converter

This block turns one IEEE-754 binary64 value into a signed two's-complement integer. Any fraction is dropped by rounding toward zero, whatever rounding setting exists elsewhere in the machine. The result is either 32 or 64 bits wide. Two control bits choose the width: a long-mode input and a width bit. The wide form is used only when both bits are high. When the long-mode input is low, the width bit has no effect.

The block reports two exception flags, invalid and inexact. Values that cannot be represented return the "integer indefinite" pattern for the selected width and raise invalid. This covers out-of-range magnitudes, NaNs and infinities. The block also checks a 4-bit reserved specifier field that travels with the operation. If that field is not all ones, it raises an undefined-opcode flag.

Operands enter through a valid/ready stream and results leave through another one. There is exactly one register stage between them.

Back-pressure rules:
- An operand is taken on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high when the output register is empty, or when it is being drained in the same cycle.
- While `out_valid` is high and `out_ready` is low, the output register holds all of its fields unchanged.

Top module: `f2i_trunc_conv`

## Requirements
- R1: An accepted operand `in_src` is read as binary64: sign at bit 63, biased exponent at bits 62:52, fraction at bits 51:0.
- R2: Finite in-range values are truncated toward zero, for both signs (2.5 gives 2, -123.75 gives -123).
- R3: A 64-bit result is produced only when `in_mode64` and `in_wide` are both 1. Otherwise the result is 32 bits, and `out_data[63:32]` is zero. `in_wide` has no effect when `in_mode64` is 0.
- R4: In 32-bit operation, a truncated value outside [-2^31, 2^31-1] sets invalid and returns 0x0000_0000_8000_0000.
- R5: In 64-bit operation, a truncated value outside [-2^63, 2^63-1] sets invalid and returns 0x8000_0000_0000_0000.
- R6: Every NaN (quiet or signaling) and both infinities set invalid and return the indefinite pattern for the selected width.
- R7: Inexact is set exactly when nonzero fraction bits are discarded and invalid is clear. Invalid and inexact are never both set.
- R8: A value that truncates to exactly the most negative integer is valid. -2^31-0.5 in 32-bit mode gives 0x8000_0000 with inexact. -2^63 in 64-bit mode gives 0x8000_0000_0000_0000 with no flags. +2^31 in 32-bit mode is invalid.
- R9: Zero of either sign, subnormals and all magnitudes below 1.0 return 0. Inexact is set only if the input is nonzero.
- R10: `out_undef` is 1 exactly when the accepted `in_vspec` differs from 4'b1111. The data result and the two exception flags do not depend on it.
- R11: The result appears one cycle after acceptance. `in_ready` equals `!out_valid || out_ready`. The output holds steady while stalled.
- R12: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand valid |
| in_ready | output | 1 | Block can take an operand |
| in_src | input | 64 | Binary64 operand |
| in_mode64 | input | 1 | Long mode active |
| in_wide | input | 1 | Width bit; selects 64-bit result in long mode |
| in_vspec | input | 4 | Reserved specifier; must be 4'b1111 |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Signed result; 32-bit results zero-extended |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Precision flag |
| out_undef | output | 1 | Undefined-opcode flag |

## Verification
The bench targets several edges:
- The two most-negative integers. A converter that checks range on magnitude alone would flag -2^31-0.5 and -2^63 as invalid.
- +2^31 in narrow mode. An off-by-one limit would return 0x8000_0000 without invalid.
- The width selection. Setting the width bit outside long mode must still give a 32-bit overflow; a wrong gate would give a clean 64-bit value.
- NaN payloads, infinities, negative zero and subnormals. A decoder that mishandles them would leak garbage bits or raise inexact on exact zero.
- A stalled output with a second operand waiting. This exposes a register that overwrites or drops a result under back-pressure.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  localparam int EXP_W = 11;
  localparam int MAN_W = 52;
  localparam int BIAS  = 1023;
  localparam int DBL_W = 1 + EXP_W + MAN_W;
  localparam int SHW   = 6;

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] exp;
    logic [MAN_W-1:0] man;
  } dbl_t;

  typedef struct packed {
    logic        sign;
    logic        special;
    logic        tiny;
    logic        tiny_nz;
    logic        k_over;
    logic [SHW-1:0] k;
  } dcls_t;
endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
  import f2i_pkg::*;
(
  input  logic [DBL_W-1:0] src,
  output dcls_t            cls,
  output logic [MAN_W-1:0] man
);
  localparam logic [EXP_W-1:0] BIAS_V = EXP_W'(BIAS);
  localparam logic [EXP_W-1:0] KMAX   = EXP_W'((1 << SHW) - 1);

  dbl_t d;
  logic [EXP_W-1:0] kfull;

  always_comb begin
    d           = dbl_t'(src);
    kfull       = d.exp - BIAS_V;
    cls.sign    = d.sign;
    cls.special = &d.exp;
    cls.tiny    = d.exp < BIAS_V;
    cls.tiny_nz = |{d.exp, d.man};
    cls.k_over  = !cls.tiny && (kfull > KMAX);
    cls.k       = kfull[SHW-1:0];
    man         = d.man;
  end
endmodule

// File: rtl/f2i_align.sv
module f2i_align
  import f2i_pkg::*;
#(
  parameter int OUT_W = 64
) (
  input  logic [MAN_W-1:0] man,
  input  logic [SHW-1:0]   k,
  output logic [OUT_W-1:0] mag,
  output logic             lost
);
  localparam logic [SHW-1:0] PT = SHW'(MAN_W);

  logic [OUT_W-1:0] sig;
  logic [SHW-1:0]   sh;

  always_comb begin
    sig = OUT_W'({1'b1, man});
    if (k <= PT) begin
      sh   = PT - k;
      mag  = sig >> sh;
      lost = |(sig & ((OUT_W'(1) << sh) - OUT_W'(1)));
    end else begin
      sh   = k - PT;
      mag  = sig << sh;
      lost = 1'b0;
    end
  end
endmodule

// File: rtl/f2i_range.sv
module f2i_range
  import f2i_pkg::*;
#(
  parameter int RES_W = 32,
  parameter int OUT_W = 64
) (
  input  dcls_t            cls,
  input  logic [OUT_W-1:0] mag,
  input  logic             lost,
  output logic [OUT_W-1:0] res,
  output logic             inv,
  output logic             inex
);
  localparam logic [OUT_W-1:0] LIMIT = OUT_W'(1) << (RES_W - 1);
  localparam logic [OUT_W-1:0] WMASK = {OUT_W{1'b1}} >> (OUT_W - RES_W);

  logic             ovf;
  logic [OUT_W-1:0] sval;

  always_comb begin
    ovf  = !cls.tiny && (cls.k_over || (mag > LIMIT) || ((mag == LIMIT) && !cls.sign));
    sval = cls.sign ? (~mag + OUT_W'(1)) : mag;
    inv  = 1'b0;
    inex = 1'b0;
    res  = '0;
    if (cls.special || ovf) begin
      inv = 1'b1;
      res = LIMIT;
    end else if (cls.tiny) begin
      inex = cls.tiny_nz;
    end else begin
      res  = sval & WMASK;
      inex = lost;
    end
  end
endmodule

// File: rtl/f2i_trunc_conv.sv
module f2i_trunc_conv
  import f2i_pkg::*;
#(
  parameter int NARROW_W = 32,
  parameter int WIDE_W   = 64,
  parameter int SPEC_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DBL_W-1:0]  in_src,
  input  logic              in_mode64,
  input  logic              in_wide,
  input  logic [SPEC_W-1:0] in_vspec,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WIDE_W-1:0] out_data,
  output logic              out_invalid,
  output logic              out_inexact,
  output logic              out_undef
);
  localparam int NUM_W = 2;

  dcls_t            cls;
  logic [MAN_W-1:0] man;
  logic [WIDE_W-1:0] mag;
  logic             lost;
  logic [WIDE_W-1:0] res_w [NUM_W];
  logic [NUM_W-1:0] inv_w;
  logic [NUM_W-1:0] inex_w;
  logic             sel;
  logic             accept;

  f2i_unpack u_unpack (.src(in_src), .cls(cls), .man(man));

  f2i_align #(.OUT_W(WIDE_W)) u_align (
    .man(man), .k(cls.k), .mag(mag), .lost(lost)
  );

  for (genvar gi = 0; gi < NUM_W; gi++) begin : g_width
    localparam int RW = (gi == 0) ? NARROW_W : WIDE_W;
    f2i_range #(.RES_W(RW), .OUT_W(WIDE_W)) u_range (
      .cls(cls), .mag(mag), .lost(lost),
      .res(res_w[gi]), .inv(inv_w[gi]), .inex(inex_w[gi])
    );
  end

  assign sel      = in_mode64 & in_wide;
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
      out_undef   <= 1'b0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_data    <= res_w[sel];
      out_invalid <= inv_w[sel];
      out_inexact <= inex_w[sel];
      out_undef   <= (in_vspec != {SPEC_W{1'b1}});
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/f2i_trunc_conv_chk.sv
module f2i_trunc_conv_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        in_mode64,
  input logic        in_wide,
  input logic [3:0]  in_vspec,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_data,
  input logic        out_invalid,
  input logic        out_inexact,
  input logic        out_undef
);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_invalid)
      && $stable(out_inexact) && $stable(out_undef));

  a_r11_load: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r10_undef: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_undef == ($past(in_vspec) != 4'hF));

  a_r7_excl: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_invalid && out_inexact));

  a_r4_indef: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_invalid |-> (out_data == 64'h0000_0000_8000_0000)
      || (out_data == 64'h8000_0000_0000_0000));

  a_r3_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !(in_mode64 && in_wide) |=> out_data[63:32] == 32'h0);
endmodule

bind f2i_trunc_conv f2i_trunc_conv_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_mode64(in_mode64), .in_wide(in_wide), .in_vspec(in_vspec),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_invalid(out_invalid), .out_inexact(out_inexact), .out_undef(out_undef)
);

// File: tb/f2i_trunc_conv_tb.sv
`timescale 1ns/1ps
module f2i_trunc_conv_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_src = '0;
  logic        in_mode64 = 1'b0;
  logic        in_wide = 1'b0;
  logic [3:0]  in_vspec = 4'hF;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic        out_invalid;
  logic        out_inexact;
  logic        out_undef;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  f2i_trunc_conv u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src(in_src), .in_mode64(in_mode64), .in_wide(in_wide), .in_vspec(in_vspec),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_invalid(out_invalid), .out_inexact(out_inexact), .out_undef(out_undef)
  );

  // {req[3:0], src[63:0], mode64, wide, expected[63:0], invalid, inexact}
  localparam int NV = 22;
  localparam logic [135:0] VEC [NV] = '{
    {4'd2, 64'h3FF0000000000000, 1'b0, 1'b0, 64'h0000000000000001, 1'b0, 1'b0}, // R2
    {4'd2, 64'h405EF00000000000, 1'b0, 1'b0, 64'h000000000000007B, 1'b0, 1'b1}, // R2
    {4'd2, 64'hC05EF00000000000, 1'b0, 1'b0, 64'h00000000FFFFFF85, 1'b0, 1'b1}, // R2
    {4'd2, 64'hC05EF00000000000, 1'b1, 1'b1, 64'hFFFFFFFFFFFFFF85, 1'b0, 1'b1}, // R2
    {4'd4, 64'h41DFFFFFFFC00000, 1'b0, 1'b0, 64'h000000007FFFFFFF, 1'b0, 1'b0}, // R4
    {4'd8, 64'h41E0000000000000, 1'b0, 1'b0, 64'h0000000080000000, 1'b1, 1'b0}, // R8
    {4'd3, 64'h41E0000000000000, 1'b1, 1'b1, 64'h0000000080000000, 1'b0, 1'b0}, // R3
    {4'd8, 64'hC1E0000000100000, 1'b0, 1'b0, 64'h0000000080000000, 1'b0, 1'b1}, // R8
    {4'd3, 64'h4270000000000000, 1'b1, 1'b1, 64'h0000010000000000, 1'b0, 1'b0}, // R3
    {4'd3, 64'h4270000000000000, 1'b0, 1'b1, 64'h0000000080000000, 1'b1, 1'b0}, // R3
    {4'd4, 64'h4270000000000000, 1'b1, 1'b0, 64'h0000000080000000, 1'b1, 1'b0}, // R4
    {4'd5, 64'h43E0000000000000, 1'b1, 1'b1, 64'h8000000000000000, 1'b1, 1'b0}, // R5
    {4'd8, 64'hC3E0000000000000, 1'b1, 1'b1, 64'h8000000000000000, 1'b0, 1'b0}, // R8
    {4'd6, 64'h7FF0000000000000, 1'b0, 1'b0, 64'h0000000080000000, 1'b1, 1'b0}, // R6
    {4'd6, 64'hFFF0000000000000, 1'b1, 1'b1, 64'h8000000000000000, 1'b1, 1'b0}, // R6
    {4'd6, 64'h7FF8000000000000, 1'b1, 1'b1, 64'h8000000000000000, 1'b1, 1'b0}, // R6
    {4'd6, 64'h7FF0000000000001, 1'b0, 1'b0, 64'h0000000080000000, 1'b1, 1'b0}, // R6
    {4'd9, 64'h3FE0000000000000, 1'b0, 1'b0, 64'h0000000000000000, 1'b0, 1'b1}, // R9
    {4'd9, 64'h8000000000000000, 1'b1, 1'b1, 64'h0000000000000000, 1'b0, 1'b0}, // R9
    {4'd9, 64'h0000000000000001, 1'b1, 1'b1, 64'h0000000000000000, 1'b0, 1'b1}, // R9
    {4'd7, 64'hBFE0000000000000, 1'b1, 1'b1, 64'h0000000000000000, 1'b0, 1'b1}, // R7
    {4'd1, 64'hC004000000000000, 1'b1, 1'b1, 64'hFFFFFFFFFFFFFFFE, 1'b0, 1'b1}  // R1
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [63:0] src, input logic m, input logic w, input logic [3:0] vs);
    @(negedge clk);
    in_src = src; in_mode64 = m; in_wide = w; in_vspec = vs; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 out_valid in reset", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 out_valid after reset", {63'd0, out_valid}, 64'd0);
    chk("R12 in_ready after reset", {63'd0, in_ready}, 64'd1);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][131:68], VEC[i][67], VEC[i][66], 4'hF);
      chk($sformatf("R%0d vec %0d data/flags", VEC[i][135:132], i),
          {out_data[61:0], out_invalid, out_inexact},
          {VEC[i][63:2], VEC[i][1], VEC[i][0]});
      chk($sformatf("R%0d vec %0d top bits/valid/undef", VEC[i][135:132], i),
          {59'd0, out_data[63:62], out_valid, out_undef},
          {59'd0, VEC[i][65:64], 1'b1, 1'b0});
    end

    // R10: bad specifier flags undef but leaves result alone
    send(64'h405EF00000000000, 1'b0, 1'b0, 4'b0111);
    chk("R10 undef set", {63'd0, out_undef}, 64'd1);
    chk("R10 data unaffected", out_data, 64'h7B);
    chk("R10 inexact unaffected", {62'd0, out_invalid, out_inexact}, 64'd1);
    send(64'h3FF0000000000000, 1'b0, 1'b0, 4'hF);
    chk("R10 undef clear", {63'd0, out_undef}, 64'd0);

    // R11: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_src = 64'h4000000000000000; in_mode64 = 1'b0; in_wide = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    chk("R11 first result", out_data, 64'd2);
    chk("R11 in_ready low when stalled", {63'd0, in_ready}, 64'd0);
    in_src = 64'h4270000000000000; in_mode64 = 1'b1; in_wide = 1'b1;
    @(negedge clk);
    chk("R11 held under stall", {out_data[62:0], out_valid}, {63'd2, 1'b1});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 second result after drain", out_data, 64'h0000010000000000);
    @(negedge clk);
    chk("R11 output empties", {63'd0, out_valid}, 64'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule